// File: doc/BRIEF.md
# Linked-Descriptor DMA Engine

This block is a single-channel DMA engine that works through a chain of descriptors kept in memory. Each descriptor is three consecutive 32-bit words. The first is the buffer address, the second is a count and flag word, and the third is the address of the following descriptor. Software loads the address of the first descriptor and writes the start bit. The engine then fetches each descriptor in turn and moves the buffer's bytes between memory and a byte-wide device stream. After each buffer it rewrites the count and flag word in memory as a status record, and it follows the next pointer until a descriptor carries the end-of-chain mark.

The transfer direction applies to the whole chain. In transmit, memory words are read and the bytes are offered to the device one at a time. A sideband marks the final byte of any buffer flagged as ending a packet. In receive, bytes from the device are packed into words and written to the buffer, but only into buffers whose ownership flag gives them to the engine. A per-descriptor flag raises a sticky interrupt when that descriptor completes. A status flag tells software that the engine has already read an end-of-chain mark, so appending another descriptor would come too late.

Memory is reached through a word-wide request/response port: a request stays up until it is acknowledged, and read data is valid in the acknowledge cycle. The device side uses valid/ready byte handshakes.

Top module: `dchain_dma`

## Requirements
- R1: After reset, both register reads return 0, `irq` is low, and `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: For a descriptor at byte address D, the engine reads D (buffer address), D+4 (count/flags) and D+8 (next address) in that order. Unless count/flags bit 31 is set, it then continues with the descriptor at the next address.
- R3: In transmit (direction 0), the engine sends bits 13:0 of count/flags bytes from the buffer in ascending address order. The low two bits of the buffer address are ignored. With endian bit 1 the byte at offset 0 of a word comes from bits 7:0; with endian bit 0 it comes from bits 31:24.
- R4: `tx_last` is high only together with `tx_valid`, and only on the final byte of a buffer whose count/flags bit 30 is set.
- R5: On completing a descriptor, the engine rewrites the word at D+4. Transmit sets bit 15 and receive clears bit 14. All other bits are unchanged.
- R6: In receive (direction 1), the engine writes the bytes it receives to the buffer using the same lane order as R3. Unfilled lanes of the final word are written as zero, and memory words beyond the buffer length are not written.
- R7: In receive, a descriptor whose bit 14 is clear stops the engine after its three-word fetch. The engine then makes no memory write, accepts no byte and raises no interrupt.
- R8: A descriptor with length 0 moves no data but is still written back and completed.
- R9: `irq` rises when a descriptor with count/flags bit 29 completes. It stays high until a control write with bit 3 set; if a set and a clear coincide, the set wins.
- R10: Status bit 4 (late flag) is set once the engine has read a count/flags word with bit 31 set. It is cleared by the start of a new chain.
- R11: Register 1 is the control register. Writes use bit 0 = start, bit 1 = direction, bit 2 = endian and bit 3 = interrupt clear. Reads return bit 0 = active, bit 1 = direction, bit 2 = endian, bit 3 = irq and bit 4 = late flag. Register 0 is the descriptor pointer, which is copied by start. Active clears only after the final memory transaction of the chain.
- R12: While the engine is active, the start, direction and endian bits of a control write are ignored.
- R13: A memory request holds its address, write enable and write data until acknowledged. `tx_data` and `tx_last` hold until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 pointer, 1 control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| irq | output | 1 | Sticky completion interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Device accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends a packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts receive byte |
| rx_data | input | 8 | Receive byte |

## Verification
The assertions assume that the memory answers every request eventually and that the read data present in the acknowledge cycle is the word at the requested address. They also assume that software does not rewrite a descriptor the engine is currently fetching. The bench gives the memory model, the transmit sink and the receive source pseudo-random stall patterns. It places descriptors and buffers in disjoint regions, and it changes memory contents only through the engine's own acknowledged writes while a chain runs. Control writes made during a run use only the bits that R12 says are ignored, apart from the interrupt clear.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  localparam int BIT_EOC  = 31;
  localparam int BIT_EOP  = 30;
  localparam int BIT_IE   = 29;
  localparam int BIT_SENT = 15;
  localparam int BIT_OWN  = 14;

  typedef enum logic [3:0] {
    W_IDLE, W_FBUF, W_FCTL, W_FNXT, W_TXRD, W_TXSEND, W_RXGET, W_RXWR, W_WB
  } walk_state_t;

  // lane index of byte position idx inside a word
  function automatic int lane_of(input logic [1:0] idx, input logic le);
    return le ? int'(idx) : 3 - int'(idx);
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] idx,
                                           input logic le);
    return w[8*lane_of(idx, le) +: 8];
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] idx,
                                           input logic le, input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*lane_of(idx, le) +: 8] = b;
    return r;
  endfunction

  function automatic logic [31:0] status_word(input logic [31:0] ctl, input logic rx);
    logic [31:0] r;
    r = ctl;
    if (rx) r[BIT_OWN] = 1'b0;
    else    r[BIT_SENT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/dchain_lane.sv
module dchain_lane
  import dchain_pkg::*;
(
  input  logic [31:0] word_in,
  input  logic [1:0]  idx,
  input  logic        le,
  input  logic [7:0]  byte_in,
  output logic [7:0]  byte_out,
  output logic [31:0] word_out
);
  always_comb begin
    byte_out = lane_pick(word_in, idx, le);
    word_out = lane_put(word_in, idx, le, byte_in);
  end
endmodule

// File: rtl/dchain_regs.sv
module dchain_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          addr,
  input  logic [31:0]   wdata,
  input  logic          active,
  input  logic          ev_eoc_seen,
  input  logic          ev_irq,
  output logic [31:0]   rdata,
  output logic [AW-1:0] ptr,
  output logic          dir,
  output logic          le,
  output logic          start_q,
  output logic          irq
);
  logic late_q;
  logic busy;
  logic ctl_wr;

  assign busy   = active | start_q;
  assign ctl_wr = wr & addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      dir     <= 1'b0;
      le      <= 1'b0;
      start_q <= 1'b0;
      irq     <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr && !addr) ptr <= wdata[AW-1:0];
      if (ctl_wr && !busy) begin
        dir     <= wdata[1];
        le      <= wdata[2];
        start_q <= wdata[0];
      end
      if (start_q)          late_q <= 1'b0;
      else if (ev_eoc_seen) late_q <= 1'b1;
      if (ev_irq)                    irq <= 1'b1;
      else if (ctl_wr && wdata[3])   irq <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) rdata[AW-1:0] = ptr;
    else       rdata[4:0] = {late_q, irq, le, dir, busy};
  end
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
  import dchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          dir,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          rx_ready,
  input  logic          rx_valid,
  output logic [31:0]   word_q,
  output logic [1:0]    bidx_q,
  input  logic [31:0]   word_ins,
  output logic          active,
  output logic          ev_eoc_seen,
  output logic          ev_done,
  output logic          ev_irq
);
  localparam logic [AW-1:0] STEP = AW'(4);

  walk_state_t      st_q;
  logic [AW-1:0]    desc_q, buf_q, nxt_q;
  logic [31:0]      ctl_q;
  logic [LEN_W-1:0] rem_q;
  logic             xfer;
  logic             rem_one;

  assign active  = (st_q != W_IDLE);
  assign rem_one = (rem_q == LEN_W'(1));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    unique case (st_q)
      W_FBUF: mem_req = 1'b1;
      W_FCTL: begin mem_req = 1'b1; mem_addr = desc_q + STEP; end
      W_FNXT: begin mem_req = 1'b1; mem_addr = desc_q + STEP + STEP; end
      W_TXRD: begin mem_req = 1'b1; mem_addr = buf_q; end
      W_RXWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = buf_q; mem_wdata = word_q; end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + STEP;
        mem_wdata = status_word(ctl_q, dir);
      end
      default: ;
    endcase
  end

  assign xfer        = mem_req & mem_ack;
  assign tx_valid    = (st_q == W_TXSEND);
  assign tx_last     = tx_valid & rem_one & ctl_q[BIT_EOP];
  assign rx_ready    = (st_q == W_RXGET);
  assign ev_eoc_seen = (st_q == W_FCTL) & xfer & mem_rdata[BIT_EOC];
  assign ev_done     = (st_q == W_WB) & xfer;
  assign ev_irq      = ev_done & ctl_q[BIT_IE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      desc_q <= '0;
      buf_q  <= '0;
      nxt_q  <= '0;
      ctl_q  <= '0;
      rem_q  <= '0;
      word_q <= '0;
      bidx_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start) begin
          desc_q <= start_ptr;
          st_q   <= W_FBUF;
        end
        W_FBUF: if (xfer) begin
          buf_q <= {mem_rdata[AW-1:2], 2'b00};
          st_q  <= W_FCTL;
        end
        W_FCTL: if (xfer) begin
          ctl_q <= mem_rdata;
          st_q  <= W_FNXT;
        end
        W_FNXT: if (xfer) begin
          nxt_q  <= mem_rdata[AW-1:0];
          rem_q  <= ctl_q[LEN_W-1:0];
          bidx_q <= '0;
          word_q <= '0;
          if (dir && !ctl_q[BIT_OWN])          st_q <= W_IDLE;
          else if (ctl_q[LEN_W-1:0] == '0)     st_q <= W_WB;
          else if (dir)                        st_q <= W_RXGET;
          else                                 st_q <= W_TXRD;
        end
        W_TXRD: if (xfer) begin
          word_q <= mem_rdata;
          st_q   <= W_TXSEND;
        end
        W_TXSEND: if (tx_ready) begin
          rem_q  <= rem_q - LEN_W'(1);
          bidx_q <= bidx_q + 2'd1;
          if (rem_one) st_q <= W_WB;
          else if (bidx_q == 2'd3) begin
            buf_q <= buf_q + STEP;
            st_q  <= W_TXRD;
          end
        end
        W_RXGET: if (rx_valid) begin
          word_q <= word_ins;
          rem_q  <= rem_q - LEN_W'(1);
          bidx_q <= bidx_q + 2'd1;
          if (rem_one || bidx_q == 2'd3) st_q <= W_RXWR;
        end
        W_RXWR: if (xfer) begin
          buf_q  <= buf_q + STEP;
          word_q <= '0;
          st_q   <= (rem_q == '0) ? W_WB : W_RXGET;
        end
        W_WB: if (xfer) begin
          if (ctl_q[BIT_EOC]) st_q <= W_IDLE;
          else begin
            desc_q <= nxt_q;
            st_q   <= W_FBUF;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
  import dchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data
);
  logic          active;
  logic          ev_eoc_seen, ev_done, ev_irq;
  logic [AW-1:0] ptr;
  logic          dir, le, start_q;
  logic [31:0]   word_q, word_ins;
  logic [1:0]    bidx_q;

  dchain_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .active(active), .ev_eoc_seen(ev_eoc_seen), .ev_irq(ev_irq),
    .rdata(reg_rdata), .ptr(ptr), .dir(dir), .le(le), .start_q(start_q), .irq(irq)
  );

  dchain_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_q), .start_ptr(ptr), .dir(dir),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .rx_valid(rx_valid),
    .word_q(word_q), .bidx_q(bidx_q), .word_ins(word_ins),
    .active(active), .ev_eoc_seen(ev_eoc_seen), .ev_done(ev_done), .ev_irq(ev_irq)
  );

  dchain_lane u_lane (
    .word_in(word_q), .idx(bidx_q), .le(le), .byte_in(rx_data),
    .byte_out(tx_data), .word_out(word_ins)
  );
endmodule

// File: rtl/dchain_checker.sv
module dchain_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          rx_ready,
  input logic          active,
  input logic          irq,
  input logic          irq_clr
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R13
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !tx_valid && !rx_ready); // R11
  AST_STOP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(mem_req && mem_ack)); // R11
  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req && !tx_valid); // R6
endmodule

bind dchain_dma dchain_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .rx_ready(rx_ready), .active(active), .irq(irq),
  .irq_clr(reg_wr && reg_addr && reg_wdata[3])
);

// File: tb/tb_dchain_dma.sv
`timescale 1ns/1ps
module tb_dchain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int wr_count = 0;
  bit exp_irq;

  logic [31:0] mem  [0:1023];
  logic [31:0] emem [0:1023];
  logic [8:0]  exp_tx[$];
  logic [7:0]  rx_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  dchain_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  assign mem_rdata = mem[mem_addr[11:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // device and memory models, decided mid-cycle for the coming edge
  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      summary();
    end
    if (!rst_n) begin
      mem_ack = 0; tx_ready = 0; rx_valid = 0;
    end else begin
      mem_ack  = lfsr[0] | lfsr[3];
      tx_ready = lfsr[1] | lfsr[5];
      rx_valid = (rx_q.size() > 0) && (lfsr[2] | lfsr[7]);
      rx_data  = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
      if (mem_req && mem_ack && mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        wr_count++;
      end
      if (rx_valid && rx_ready) void'(rx_q.pop_front());
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R3 unexpected tx byte", {23'b0, tx_last, tx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          chk({tx_last, tx_data} == e, "R3 R4 tx byte/last", {23'b0, tx_last, tx_data}, {23'b0, e});
        end
      end
    end
  end

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] b, input logic [31:0] c, input logic [31:0] n);
    mem[a >> 2] = b; mem[(a >> 2) + 1] = c; mem[(a >> 2) + 2] = n;
  endtask

  task automatic snapshot();
    for (int i = 0; i < 1024; i++) emem[i] = mem[i];
    exp_irq = 0;
  endtask

  // behavioural reference: transmit chain
  task automatic model_tx(input int d0, input bit le);
    int d;
    d = d0;
    for (int n = 0; n < 16; n++) begin
      logic [31:0] b, c;
      int len;
      b = emem[d >> 2] & ~32'h3;
      c = emem[(d >> 2) + 1];
      len = int'(c[13:0]);
      for (int k = 0; k < len; k++) begin
        int a, sh;
        logic [31:0] w;
        a = int'(b) + k;
        w = emem[a >> 2];
        sh = le ? 8 * (a % 4) : 8 * (3 - a % 4);
        exp_tx.push_back({(k == len - 1) && c[30], w[sh +: 8]});
      end
      emem[(d >> 2) + 1] = c | 32'h0000_8000;
      if (c[29]) exp_irq = 1;
      if (c[31]) break;
      d = int'(emem[(d >> 2) + 2]);
    end
  endtask

  // behavioural reference: receive chain, consuming a copy of the byte feed
  task automatic model_rx(input int d0, input bit le, input logic [7:0] feed[$]);
    int d;
    d = d0;
    for (int n = 0; n < 16; n++) begin
      logic [31:0] b, c;
      b = emem[d >> 2] & ~32'h3;
      c = emem[(d >> 2) + 1];
      if (!c[14]) break;
      for (int k = 0; k < int'(c[13:0]); k++) begin
        int a, sh;
        a = int'(b) + k;
        if (k % 4 == 0) emem[a >> 2] = 32'h0;
        sh = le ? 8 * (k % 4) : 8 * (3 - k % 4);
        emem[a >> 2][sh +: 8] = feed.pop_front();
      end
      emem[(d >> 2) + 1] = c & ~32'h0000_4000;
      if (c[29]) exp_irq = 1;
      if (c[31]) break;
      d = int'(emem[(d >> 2) + 2]);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== emem[i]) begin
        if (bad == 0) $display("  word %0d differs: %h vs %h", i, mem[i], emem[i]);
        bad++;
      end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_wait(input string req);
    logic [31:0] s;
    int n;
    n = 0;
    do begin
      reg_read(1'b1, s);
      n++;
    end while (s[0] && n < 20000);
    chk(!s[0], req, s, 0);
  endtask

  initial begin
    logic [31:0] s;
    logic [7:0] feed[$];
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h1357_2468;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(1'b0, s); chk(s == 0, "R1 pointer after reset", s, 0);
    reg_read(1'b1, s); chk(s == 0, "R1 status after reset", s, 0);
    chk(!irq && !mem_req && !tx_valid && !rx_ready, "R1 outputs idle",
        {irq, mem_req, tx_valid, rx_ready}, 0);

    // Test A: transmit, little endian, three descriptors incl. zero length
    put_desc(32'h100, 32'h402, 32'h0000_0005, 32'h110);
    put_desc(32'h110, 32'h420, 32'h2000_0000, 32'h120);
    put_desc(32'h120, 32'h440, 32'hC000_0007, 32'h0);
    snapshot();
    model_tx(32'h100, 1'b1);
    reg_write(1'b0, 32'h100);
    reg_write(1'b1, 32'h5);
    repeat (3) @(negedge clk);
    reg_read(1'b1, s);
    chk(s[0] == 1 && s[4] == 0, "R10 late flag clear while first descriptor runs", s, 32'h5);
    reg_write(1'b1, 32'h3);
    reg_read(1'b1, s);
    chk(s[1] == 0 && s[2] == 1, "R12 direction/endian write ignored while active", s, 32'h5);
    run_wait("R11 active clears after chain A");
    chk(exp_tx.size() == 0, "R2 R3 all tx bytes of chain A delivered", exp_tx.size(), 0);
    cmp_mem("R5 R8 transmit write-back and untouched buffers");
    reg_read(1'b1, s);
    chk(s[4] == 1, "R10 late flag set after end of chain", s, 32'h10);
    chk(irq == exp_irq && s[3] == 1, "R9 R8 irq from zero-length descriptor", irq, exp_irq);
    repeat (20) @(negedge clk);
    chk(irq == 1, "R9 irq stays set", irq, 1);
    reg_write(1'b1, 32'h8);
    @(negedge clk);
    chk(irq == 0, "R9 irq cleared by clear bit", irq, 0);
    reg_read(1'b0, s); chk(s == 32'h100, "R11 pointer readback", s, 32'h100);

    // Test B: transmit, big endian, crosses a word
    put_desc(32'h200, 32'h480, 32'hC000_0006, 32'h0);
    snapshot();
    model_tx(32'h200, 1'b0);
    reg_write(1'b0, 32'h200);
    reg_write(1'b1, 32'h1);
    run_wait("R11 active clears after chain B");
    chk(exp_tx.size() == 0, "R3 big-endian bytes delivered", exp_tx.size(), 0);
    cmp_mem("R5 big-endian write-back");
    chk(irq == 0, "R9 no irq without bit 29", irq, 0);

    // Test C: receive, little endian, two owned buffers
    put_desc(32'h300, 32'h500, 32'h0000_4006, 32'h310);
    put_desc(32'h310, 32'h540, 32'hA000_4003, 32'h0);
    feed = {};
    for (int i = 0; i < 9; i++) feed.push_back(8'(8'h31 + 8'(i * 7)));
    snapshot();
    model_rx(32'h300, 1'b1, feed);
    rx_q = feed;
    reg_write(1'b0, 32'h300);
    reg_write(1'b1, 32'h7);
    run_wait("R11 active clears after chain C");
    chk(rx_q.size() == 0, "R6 all receive bytes taken", rx_q.size(), 0);
    cmp_mem("R6 R5 receive buffers zero-filled and ownership returned");
    chk(irq == 1, "R9 irq from receive descriptor", irq, 1);
    reg_write(1'b1, 32'h8);

    // Test D: receive, big endian, five bytes
    put_desc(32'h380, 32'h580, 32'h8000_4005, 32'h0);
    feed = {};
    for (int i = 0; i < 5; i++) feed.push_back(8'(8'hC0 ^ 8'(i * 13)));
    snapshot();
    model_rx(32'h380, 1'b0, feed);
    rx_q = feed;
    reg_write(1'b0, 32'h380);
    reg_write(1'b1, 32'h3);
    run_wait("R11 active clears after chain D");
    cmp_mem("R6 big-endian receive packing");

    // Test E: receive into a buffer the engine does not own
    put_desc(32'h3C0, 32'h5C0, 32'h2000_0004, 32'h3D0);
    snapshot();
    rx_q = {8'h11, 8'h22, 8'h33, 8'h44};
    wr_count = 0;
    reg_write(1'b0, 32'h3C0);
    reg_write(1'b1, 32'h3);
    run_wait("R7 engine stops on unowned buffer");
    chk(wr_count == 0, "R7 no memory writes", wr_count, 0);
    chk(rx_q.size() == 4, "R7 no bytes accepted", rx_q.size(), 4);
    cmp_mem("R7 memory untouched");
    chk(irq == 0, "R7 no interrupt", irq, 0);
    reg_read(1'b1, s);
    chk(s[4] == 0, "R10 late flag cleared by new start", s, 0);
    rx_q = {};

    summary();
  end
endmodule